// File: doc/BRIEF.md
# DRAM read-offset leveling sequencer

This block calibrates the read strobe delay of a 32-bit DRAM data path, one byte lane at a time, with no software involved. When `start` is pulsed it stores a four-word test pattern in memory at a base address chosen by the channel index. For each of the four byte lanes it then looks for the first offset that reads back correctly in two directions. The first search climbs from a lower limit and the second descends from an upper limit. Both limits are derived from the delay-line coarse lock value.

Each lane's result is the midpoint of the two edges it found. The four results are packed into one offset word, which drives the read delay lines directly. Every change of that word is followed by a one-cycle resync strobe, so the slave delay lines take the new setting. When the final word is written, `done` pulses and the word stays on the output until the next run.

Top module: `rdlvl_engine`

## Requirements
- R1: Out of reset `busy`, `done`, `resync` and `req_valid` are 0 and `offset_word` is 0x00000000.
- R2: After `start`, the block issues exactly four writes before any read. Their addresses are base+0, +4, +8 and +12, where base = BASE_ADDR + chan*0x80. Their data, in that order, is 0x5A5A5A5A, 0xA5A5A5A5, 0xF0F0F0F0 and 0x0F0F0F0F. Every read falls inside those four words.
- R3: An offset passes for lane k (bits 8k+7:8k) only if byte k of all four read-back words equals byte k of the word written there. A mismatch in any one word fails that offset.
- R4: Each offset byte is sign-magnitude: bit 7 is the sign and bits 6:0 hold |v|. The value 0x80 (negative zero) never appears.
- R5: The lower limit is 8 - coarse. The upper limit is 8 + coarse, clamped to at most 127.
- R6: Before each lane's search, `offset_word` is set to 0x08080808 and the lane's result is preset to 8. If no offset in range passes, the result stays 8.
- R7: First pass: lanes 0 to 3, each stepping +1 from the lower limit to the upper limit inclusive. Second pass: lanes 0 to 3, each stepping -1 from the upper limit to the lower limit inclusive. Each search stops at the first passing offset.
- R8: During a search only the byte of the lane under test changes. The other bytes keep their values.
- R9: A new `offset_word` value becomes visible in a cycle in which `resync` is 1. `resync` is never high for two cycles in a row.
- R10: The final word holds, per lane, (left+right)/2 truncated toward zero, sign-magnitude encoded. It is written with a resync, and `done` pulses in that same cycle. The word then holds until the next start.
- R11: `busy` rises the cycle after an accepted `start` and stays high until `done`. A `start` while busy is ignored.
- R12: A single read is outstanding at a time. No new request is issued until its `rd_valid` has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| coarse | input | 7 | Delay-line coarse lock value |
| chan | input | CHAN_W | Channel index selecting the test base address |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Byte address |
| req_wdata | output | 32 | Write data |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 32 | Read data |
| offset_word | output | 32 | Packed per-lane read offset, lane k in bits 8k+7:8k |
| resync | output | 1 | One-cycle delay-line update strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory side behaves as follows:
- `rd_valid` returns exactly once for each accepted read, and never without one.
- `rd_valid` never comes back in the same cycle that the read is accepted.
- `start` is a short pulse.

The bench memory model holds `req_ready` low between accepted requests and returns each read after a delay of one to three cycles. It makes pass or fail depend on a per-lane window of decoded offsets. A lane outside its window is corrupted in only one of the four pattern words, and that word differs for each lane. The extra `start` that the bench drives mid-run falls while the block is busy, so the expected sequence does not change.

// File: rtl/rdlvl_engine.sv
module rdlvl_engine #(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_0000,
  parameter int          CHAN_STRIDE = 128,
  parameter int          CHAN_W      = 1,
  parameter int          DEFAULT_OFS = 8,
  parameter int          MAX_OFS     = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [6:0]        coarse,
  input  logic [CHAN_W-1:0] chan,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [31:0]       req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic [31:0]       offset_word,
  output logic              resync,
  output logic              busy,
  output logic              done
);

  localparam logic [7:0]        DEF_B = 8'(DEFAULT_OFS);
  localparam logic signed [8:0] DEF_S = 9'(DEFAULT_OFS);
  localparam logic signed [8:0] MAX_S = 9'(MAX_OFS);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_DFLT, S_SET, S_SYNC, S_RD, S_RWAIT, S_FINAL} st_t;
  typedef enum logic [1:0] {PH_SET, PH_RD, PH_END} ph_t;

  st_t               st;
  ph_t               ph;
  logic [1:0]        widx, ridx, lane;
  logic              dir, ok;
  logic signed [8:0] shift, left_q, right_q;
  logic [CHAN_W-1:0] chan_q;
  logic signed [8:0] res_l [4];
  logic signed [8:0] res_r [4];

  function automatic logic [31:0] pat(input logic [1:0] i);
    case (i)
      2'd0:    return 32'h5A5A_5A5A;
      2'd1:    return 32'hA5A5_A5A5;
      2'd2:    return 32'hF0F0_F0F0;
      default: return 32'h0F0F_0F0F;
    endcase
  endfunction

  function automatic logic [7:0] sm(input logic signed [8:0] v);
    logic signed [8:0] m;
    m = -v;
    if (v < 0) return {1'b1, m[6:0]};
    return {1'b0, v[6:0]};
  endfunction

  logic signed [8:0] sweep_start, sweep_end, sum_r;
  logic [31:0]       base_addr, final_word;
  logic [1:0]        aidx;
  logic              match, pass_now;

  assign sweep_start = dir ? right_q : left_q;
  assign sweep_end   = dir ? left_q  : right_q;
  assign sum_r       = DEF_S + $signed({2'b00, coarse});
  assign base_addr   = BASE_ADDR + 32'(chan_q) * 32'(CHAN_STRIDE);
  assign aidx        = (st == S_WR) ? widx : ridx;
  assign match       = rd_data[{lane, 3'b000} +: 8] == pat(ridx)[{lane, 3'b000} +: 8];
  assign pass_now    = ok & match;

  always_comb begin
    final_word = '0;
    for (int i = 0; i < 4; i++) begin
      logic signed [9:0] s, h;
      s = $signed({res_l[i][8], res_l[i]}) + $signed({res_r[i][8], res_r[i]});
      h = s / 10'sd2;
      final_word[i*8 +: 8] = sm(h[8:0]);
    end
  end

  assign req_valid = (st == S_WR) || (st == S_RD);
  assign req_we    = (st == S_WR);
  assign req_addr  = base_addr + {28'd0, aidx, 2'b00};
  assign req_wdata = (st == S_WR) ? pat(widx) : 32'd0;
  assign resync    = (st == S_SYNC);
  assign done      = (st == S_SYNC) && (ph == PH_END);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= PH_SET;
      widx        <= '0;
      ridx        <= '0;
      lane        <= '0;
      dir         <= 1'b0;
      ok          <= 1'b0;
      shift       <= '0;
      left_q      <= '0;
      right_q     <= '0;
      chan_q      <= '0;
      offset_word <= '0;
      for (int i = 0; i < 4; i++) begin
        res_l[i] <= DEF_S;
        res_r[i] <= DEF_S;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          left_q  <= DEF_S - $signed({2'b00, coarse});
          right_q <= (sum_r > MAX_S) ? MAX_S : sum_r;
          chan_q  <= chan;
          widx    <= '0;
          st      <= S_WR;
        end
        S_WR: if (req_ready) begin
          if (widx == 2'd3) begin
            dir  <= 1'b0;
            lane <= '0;
            st   <= S_DFLT;
          end else begin
            widx <= widx + 2'd1;
          end
        end
        S_DFLT: begin
          offset_word <= {4{DEF_B}};
          if (dir) res_r[lane] <= DEF_S;
          else     res_l[lane] <= DEF_S;
          shift <= sweep_start;
          ph    <= PH_SET;
          st    <= S_SYNC;
        end
        S_SET: begin
          offset_word[{lane, 3'b000} +: 8] <= sm(shift);
          ph <= PH_RD;
          st <= S_SYNC;
        end
        S_SYNC: begin
          case (ph)
            PH_SET: st <= S_SET;
            PH_RD: begin
              ridx <= '0;
              ok   <= 1'b1;
              st   <= S_RD;
            end
            default: st <= S_IDLE;
          endcase
        end
        S_RD: if (req_ready) st <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          if (ridx != 2'd3) begin
            ok   <= pass_now;
            ridx <= ridx + 2'd1;
            st   <= S_RD;
          end else if (pass_now || shift == sweep_end) begin
            if (pass_now) begin
              if (dir) res_r[lane] <= shift;
              else     res_l[lane] <= shift;
            end
            if (lane == 2'd3) begin
              lane <= '0;
              if (dir) st <= S_FINAL;
              else begin
                dir <= 1'b1;
                st  <= S_DFLT;
              end
            end else begin
              lane <= lane + 2'd1;
              st   <= S_DFLT;
            end
          end else begin
            shift <= dir ? shift - 9'sd1 : shift + 9'sd1;
            st    <= S_SET;
          end
        end
        S_FINAL: begin
          offset_word <= final_word;
          ph <= PH_END;
          st <= S_SYNC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdlvl_engine_chk.sv
module rdlvl_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic [31:0] req_wdata,
  input logic        rd_valid,
  input logic [31:0] offset_word,
  input logic        resync,
  input logic        busy,
  input logic        done
);

  logic rd_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (req_valid && req_ready && !req_we) rd_pend <= 1'b1;
    else if (rd_valid) rd_pend <= 1'b0;
  end

  // R9
  resync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) resync |=> !resync);

  // R9
  word_sync_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(offset_word) |-> resync);

  // R10
  done_sync_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> resync && busy);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> $stable(offset_word));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_pend |-> !req_valid);

  // R2
  wdata_pat_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_we) |->
    (req_wdata == 32'h5A5A_5A5A || req_wdata == 32'hA5A5_A5A5 ||
     req_wdata == 32'hF0F0_F0F0 || req_wdata == 32'h0F0F_0F0F));

  // R4
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++)
        no_negzero_chk: assert (offset_word[i*8 +: 8] != 8'h80);
    end
  end

endmodule

bind rdlvl_engine rdlvl_engine_chk chk_i (.*);

// File: tb/rdlvl_engine_test.sv
`timescale 1ns/1ps
module rdlvl_engine_test;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [6:0]  coarse = 0;
  logic [0:0]  chan = 0;
  logic        req_valid, req_we, req_ready = 0, rd_valid = 0;
  logic [31:0] req_addr, req_wdata, rd_data = 0, offset_word;
  logic        resync, busy, done;

  always #4 clk = ~clk;

  rdlvl_engine uut (.*);

  int errors = 0, checks = 0, cyc = 0;
  int lo [4], hi [4];
  logic [31:0] mem [4];
  logic [31:0] exp_q [$];
  logic [31:0] exp_final;
  int wr_seen, rd_seen, gap, rd_cnt, rd_idx, cur_chan;
  logic prev_resync;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int v);
    if (v < 0) return 8'h80 | 8'(-v);
    return 8'(v);
  endfunction

  function automatic int dec(input logic [7:0] b);
    if (b[7]) return -int'(b[6:0]);
    return int'(b[6:0]);
  endfunction

  function automatic logic [31:0] patw(input int i);
    case (i)
      0: return 32'h5A5A5A5A;
      1: return 32'hA5A5A5A5;
      2: return 32'hF0F0F0F0;
      default: return 32'h0F0F0F0F;
    endcase
  endfunction

  // Reference: R5 limits, R6 default, R7 order, R8 single-lane change, R10 midpoint
  task automatic build(input int c);
    int left, right, res[2][4];
    logic [31:0] cur, fin;
    left = 8 - c;
    right = 8 + c;
    if (right > 127) right = 127;
    exp_q.delete();
    for (int d = 0; d < 2; d++)
      for (int l = 0; l < 4; l++) begin
        int s, e, r;
        cur = 32'h08080808;
        exp_q.push_back(cur);
        r = 8;
        s = d ? right : left;
        e = d ? left : right;
        forever begin
          cur[l*8 +: 8] = enc(s);
          exp_q.push_back(cur);
          if (s >= lo[l] && s <= hi[l]) begin r = s; break; end
          if (s == e) break;
          s = d ? s - 1 : s + 1;
        end
        res[d][l] = r;
      end
    fin = 0;
    for (int l = 0; l < 4; l++) fin[l*8 +: 8] = enc((res[0][l] + res[1][l]) / 2);
    exp_q.push_back(fin);
    exp_final = fin;
  endtask

  // memory model and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 180000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      // R9 R10: each visible offset word matches the model, done only with the last
      chk(done === (resync && exp_q.size() == 1), "R10", "done timing", 32'(done), 32'(resync && exp_q.size() == 1));
      if (resync) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected resync", offset_word, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(offset_word === e, "R7 R8", "offset word at resync", offset_word, e);
        end
      end
      chk(!(resync && prev_resync), "R9", "resync width", 32'(resync), 0);
    end
    prev_resync = resync;

    req_ready = 0;
    rd_valid = 0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        logic [31:0] w;
        w = mem[rd_idx];
        // R3: lane l is corrupted only in word l when outside its window
        for (int l = 0; l < 4; l++) begin
          int v;
          v = dec(offset_word[l*8 +: 8]);
          if (rd_idx == l && !(v >= lo[l] && v <= hi[l])) w[l*8 +: 8] = ~w[l*8 +: 8];
        end
        rd_data = w;
        rd_valid = 1;
      end
    end
    if (rst_n && req_valid && rd_cnt == 0) begin
      if (gap > 0) gap--;
      else begin
        logic [31:0] base;
        base = 32'(cur_chan) * 32'h80;
        req_ready = 1;
        gap = (cyc * 7) % 3;
        if (req_we) begin
          chk(wr_seen < 4 && req_addr == base + 32'(wr_seen * 4), "R2", "write address", req_addr, base + 32'(wr_seen * 4));
          chk(req_wdata == patw(wr_seen), "R2", "write data", req_wdata, patw(wr_seen));
          if (req_addr >= base && req_addr < base + 16) mem[(req_addr - base) >> 2] = req_wdata;
          wr_seen++;
        end else begin
          chk(wr_seen == 4 && req_addr >= base && req_addr < base + 16, "R2", "read address", req_addr, base);
          rd_idx = int'((req_addr - base) >> 2) & 3;
          rd_cnt = 1 + (cyc % 3);
          rd_seen++;
        end
      end
    end
  end

  task automatic run(input int c, input int ch, input bit inject);
    int n;
    build(c);
    wr_seen = 0; rd_seen = 0; cur_chan = ch;
    @(negedge clk);
    coarse = 7'(c); chan = 1'(ch); start = 1;
    @(negedge clk);
    start = 0; coarse = 7'(c ^ 5);
    chk(busy === 1, "R11", "busy after start", 32'(busy), 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1; coarse = 7'd3; chan = ~chan;
      @(negedge clk);
      start = 0;
      chk(busy === 1, "R11", "busy during ignored start", 32'(busy), 1);
    end
    n = 0;
    while (!done && n < 120000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(busy === 0, "R11", "idle after done", 32'(busy), 0);
    chk(exp_q.size() == 0, "R7", "resync events left", 32'(exp_q.size()), 0);
    chk(offset_word === exp_final, "R10", "final word", offset_word, exp_final);
    repeat (20) @(negedge clk);
    chk(offset_word === exp_final, "R10", "final word held", offset_word, exp_final);
  endtask

  initial begin
    gap = 0; rd_cnt = 0; prev_resync = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 0 && done === 0 && resync === 0 && req_valid === 0, "R1", "idle outputs",
        {busy, done, resync, req_valid}, 0);
    chk(offset_word === 0, "R1", "reset word", offset_word, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 R7 R11: coarse 20, mid-run start ignored
    lo = '{0, 5, -10, 12}; hi = '{15, 25, 3, 28};
    run(20, 0, 1);

    // R6: coarse 0, single step at 8; lane 1 never passes
    lo = '{8, 50, -5, 0}; hi = '{8, 60, 8, 30};
    run(0, 1, 0);

    // R4 R5 R10: clamp at 127, negative midpoint truncation, unreachable lane
    lo = '{-9, 100, -119, 200}; hi = '{-4, 127, -119, 300};
    run(127, 1, 0);

    // R3 R8: narrow windows, corruption in one word per lane
    lo = '{3, 7, 9, 1}; hi = '{3, 10, 12, 14};
    run(6, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule